// File: doc/BRIEF.md
# Execute-Packet Dispatcher

This block sits between instruction fetch and decode in a wide-issue processor. It receives aligned groups of eight 32-bit instruction words and cuts each group into issue bundles. The cut points come from a chaining flag in bit 0 of every word. A flag of 1 links a word to the word after it, so both issue together. A flag of 0 closes the bundle. Each cycle, at most one bundle leaves the block, as an 8-bit slot mask plus the eight words. Slots outside the bundle are zeroed so that they act as no-ops. Slot position carries no meaning for unit selection.

Fetch groups enter through a valid/ready handshake. A new group is taken only in the cycle that the last bundle of the current group goes out, or when the block is empty. A redirect input flushes whatever is held. It also records the word index of the branch target. The next group accepted then starts dispatch at that word, and the words before it never issue. Groups after that one start at word 0.

Top module: `packet_dispatch`

## Requirements
- R1: After reset, `issueValid` is 0, `issueMask` is 0 and `fetchReady` is 1.
- R2: A bundle starts at the current start word and covers every following word up to and including the first word whose bit 0 is 0. Mask bit i set means word i issues.
- R3: A bundle never extends past word 7. Word 7 closes a bundle even when its bit 0 is 1.
- R4: One bundle issues per cycle. The next bundle of the same group starts at the word after the previous bundle's last word.
- R5: In `issueWords`, slot i (bits 32*i+31 down to 32*i) holds the stored word when mask bit i is set, and holds zero otherwise.
- R6: `fetchReady` is 1 only when no redirect is present and either the block holds no group or the bundle issuing now ends at word 7. A group is accepted when `fetchValid` and `fetchReady` are both 1.
- R7: The first bundle of an accepted group appears in the cycle after acceptance.
- R8: When `redirectValid` is 1, no bundle issues in that cycle and the held group is discarded. The next accepted group starts at word `redirectWord`, and its lower words never appear in a mask.
- R9: The start offset from a redirect applies only to the first group accepted after it. Later groups start at word 0.
- R10: While the block is empty and `fetchValid` is 0, `issueValid` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fetchValid | input | 1 | A fetch group is offered |
| fetchReady | output | 1 | The block takes the offered group this cycle |
| fetchWords | input | 256 | Eight words; word i in bits 32*i+31:32*i |
| redirectValid | input | 1 | Branch redirect; flushes the held group |
| redirectWord | input | 3 | Word index of the branch target inside its group |
| issueValid | output | 1 | A bundle issues this cycle |
| issueMask | output | 8 | Slots belonging to the bundle |
| issueWords | output | 256 | Bundle words, with unused slots zeroed |

## Verification
Directed groups cover the extremes of the chaining flag. With every flag clear, the group yields eight single-slot bundles, which shows that the block advances word by word. With every flag set, including word 7's, a single full bundle must come out, which shows that the boundary is forced. A redirect to word 5 followed by two groups separates the one-shot offset from a sticky one. Random groups with biased flags, random fetch gaps and occasional redirects check mask, words and ready every cycle against a bench model. These catch wrong handshake timing, words that leak into unused slots, and flush races.

// File: rtl/dispatch_pkg.sv
package dispatch_pkg;
  typedef struct packed {
    logic flush;  // redirect: drop held group, latch target word
    logic load;   // capture offered fetch group
    logic issue;  // a bundle leaves this cycle
  } ctrl_t;
endpackage

// File: rtl/dispatch_ctrl.sv
module dispatch_ctrl
  import dispatch_pkg::*;
(
  input  logic  clk,
  input  logic  rstN,
  input  logic  fetchValid,
  input  logic  redirectValid,
  input  logic  lastPkt,
  output logic  fetchReady,
  output logic  issueValid,
  output ctrl_t ctrl
);
  logic holdQ;

  assign fetchReady = !redirectValid && (!holdQ || lastPkt);
  assign issueValid = holdQ && !redirectValid;

  always_comb begin
    ctrl.flush = redirectValid;
    ctrl.issue = issueValid;
    ctrl.load  = fetchValid && fetchReady;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                    holdQ <= 1'b0;
    else if (ctrl.flush)          holdQ <= 1'b0;
    else if (ctrl.load)           holdQ <= 1'b1;
    else if (ctrl.issue && lastPkt) holdQ <= 1'b0;
  end

  // R6: a group stays held until its final bundle has gone out
  assert_hold_until_last_R6: assert property (@(posedge clk) disable iff (!rstN)
    holdQ && !lastPkt && !redirectValid |=> holdQ);
  // R7: an accepted group is held in the following cycle
  assert_load_holds_R7: assert property (@(posedge clk) disable iff (!rstN)
    fetchValid && fetchReady |=> holdQ);
endmodule

// File: rtl/dispatch_datapath.sv
module dispatch_datapath
  import dispatch_pkg::*;
#(
  parameter int SLOTS  = 8,
  parameter int WORD_W = 32,
  parameter int PBIT   = 0
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  ctrl_t                   ctrl,
  input  logic [SLOTS*WORD_W-1:0] fetchWords,
  input  logic [$clog2(SLOTS)-1:0] redirectWord,
  output logic                    lastPkt,
  output logic [SLOTS-1:0]        issueMask,
  output logic [SLOTS*WORD_W-1:0] issueWords
);
  localparam int IDX_W = $clog2(SLOTS);

  logic [SLOTS*WORD_W-1:0] wordsQ;
  logic [IDX_W-1:0]        posQ, startQ;
  logic [SLOTS-1:0]        chain, rawMask;
  logic [IDX_W:0]          span, nextPos;
  logic                    run;

  // chaining flags; the last slot always closes the bundle
  generate
    for (genvar i = 0; i < SLOTS; i++) begin : g_chain
      if (i == SLOTS - 1) begin : g_edge
        assign chain[i] = 1'b0;
      end else begin : g_mid
        assign chain[i] = wordsQ[i*WORD_W + PBIT];
      end
    end
  endgenerate

  always_comb begin
    run     = 1'b1;
    span    = '0;
    rawMask = '0;
    for (int i = 0; i < SLOTS; i++) begin
      if (i >= int'(posQ)) begin
        rawMask[i] = run;
        if (run) span = span + {{IDX_W{1'b0}}, 1'b1};
        run = run && chain[i];
      end
    end
    nextPos = {1'b0, posQ} + span;
  end

  assign lastPkt   = rawMask[SLOTS-1];
  assign issueMask = rawMask & {SLOTS{ctrl.issue}};

  generate
    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
      assign issueWords[i*WORD_W +: WORD_W] =
        issueMask[i] ? wordsQ[i*WORD_W +: WORD_W] : '0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wordsQ <= '0;
      posQ   <= '0;
      startQ <= '0;
    end else if (ctrl.flush) begin
      startQ <= redirectWord;
    end else begin
      if (ctrl.issue) posQ <= nextPos[IDX_W-1:0];
      if (ctrl.load) begin
        wordsQ <= fetchWords;
        posQ   <= startQ;
        startQ <= '0;
      end
    end
  end

  // R4: a bundle that is not the last of its group moves the start forward
  assert_progress_R4: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.issue && !lastPkt && !ctrl.load |=> posQ > $past(posQ));
endmodule

// File: rtl/packet_dispatch.sv
module packet_dispatch
  import dispatch_pkg::*;
#(
  parameter int SLOTS  = 8,
  parameter int WORD_W = 32,
  parameter int PBIT   = 0
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      fetchValid,
  output logic                      fetchReady,
  input  logic [SLOTS*WORD_W-1:0]   fetchWords,
  input  logic                      redirectValid,
  input  logic [$clog2(SLOTS)-1:0]  redirectWord,
  output logic                      issueValid,
  output logic [SLOTS-1:0]          issueMask,
  output logic [SLOTS*WORD_W-1:0]   issueWords
);
  ctrl_t ctrl;
  logic  lastPkt;

  dispatch_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .fetchValid(fetchValid),
    .redirectValid(redirectValid), .lastPkt(lastPkt),
    .fetchReady(fetchReady), .issueValid(issueValid), .ctrl(ctrl)
  );

  dispatch_datapath #(.SLOTS(SLOTS), .WORD_W(WORD_W), .PBIT(PBIT)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .fetchWords(fetchWords),
    .redirectWord(redirectWord), .lastPkt(lastPkt),
    .issueMask(issueMask), .issueWords(issueWords)
  );

  // R2: an issuing bundle always covers at least one slot; idle shows none
  assert_mask_nonempty_R2: assert property (@(posedge clk) disable iff (!rstN)
    issueValid |-> issueMask != '0);
  assert_idle_mask_R2: assert property (@(posedge clk) disable iff (!rstN)
    !issueValid |-> issueMask == '0);
  // R6: acceptance only alongside the group's final bundle or when idle
  assert_accept_last_R6: assert property (@(posedge clk) disable iff (!rstN)
    fetchValid && fetchReady |-> !issueValid || issueMask[SLOTS-1]);
  // R8: a redirect leaves nothing to issue in the next cycle
  assert_flush_R8: assert property (@(posedge clk) disable iff (!rstN)
    redirectValid |=> !issueValid);
endmodule

// File: tb/tb_packet_dispatch.sv
`timescale 1ns/1ps
module tb_packet_dispatch;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         fetchValid = 1'b0;
  logic         fetchReady;
  logic [255:0] fetchWords = '0;
  logic         redirectValid = 1'b0;
  logic [2:0]   redirectWord = '0;
  logic         issueValid;
  logic [7:0]   issueMask;
  logic [255:0] issueWords;

  int checks = 0;
  int fails  = 0;

  // bench model state
  bit           mHold = 0;
  logic [255:0] mWords = '0;
  int           mPos = 0;
  int           mStart = 0;
  logic [7:0]   seenMask;
  bit           seenValid;

  always #2.5 clk = ~clk;

  packet_dispatch dut (
    .clk(clk), .rstN(rstN), .fetchValid(fetchValid), .fetchReady(fetchReady),
    .fetchWords(fetchWords), .redirectValid(redirectValid),
    .redirectWord(redirectWord), .issueValid(issueValid),
    .issueMask(issueMask), .issueWords(issueWords)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic int bundleEnd(input logic [255:0] w, input int p);
    int e = p;
    while (e < 7 && w[e*32]) e++;
    return e;
  endfunction

  function automatic logic [7:0] bundleMask(input logic [255:0] w, input int p);
    logic [7:0] m = '0;
    for (int k = p; k <= bundleEnd(w, p); k++) m[k] = 1'b1;
    return m;
  endfunction

  function automatic logic [255:0] randGroup();
    logic [255:0] g;
    for (int k = 0; k < 8; k++) begin
      g[k*32 +: 32] = $urandom;
      g[k*32] = ($urandom % 3) != 0;
    end
    return g;
  endfunction

  // one cycle: drive at negedge, check, advance model at posedge
  task automatic step(input bit fv, input logic [255:0] w, input bit rv,
                      input logic [2:0] rw);
    logic [7:0]   eMask;
    logic [255:0] eWords;
    bit           eValid, eReady, lastB;
    fetchValid = fv; fetchWords = w; redirectValid = rv; redirectWord = rw;
    #1;
    eValid = mHold && !rv;
    eMask  = eValid ? bundleMask(mWords, mPos) : 8'h00;
    eWords = '0;
    for (int k = 0; k < 8; k++) if (eMask[k]) eWords[k*32 +: 32] = mWords[k*32 +: 32];
    lastB  = mHold && bundleEnd(mWords, mPos) == 7;
    eReady = !rv && (!mHold || lastB);
    chk(issueValid == eValid, "R7", "issueValid", 256'(issueValid), 256'(eValid));
    chk(issueMask == eMask, "R2", "issueMask", 256'(issueMask), 256'(eMask));
    chk(issueWords == eWords, "R5", "issueWords", issueWords, eWords);
    chk(fetchReady == eReady, "R6", "fetchReady", 256'(fetchReady), 256'(eReady));
    seenMask = issueMask; seenValid = issueValid;
    @(posedge clk);
    if (rv) begin
      mHold = 0; mStart = rw;
    end else begin
      if (mHold) begin
        if (lastB) mHold = 0;
        else mPos = bundleEnd(mWords, mPos) + 1;
      end
      if (fv && eReady) begin
        mHold = 1; mWords = w; mPos = mStart; mStart = 0;
      end
    end
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : stim
    logic [255:0] g;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    #1;
    chk(issueValid == 1'b0, "R1", "issueValid in reset", 256'(issueValid), 256'(0));
    rstN = 1'b1;
    @(negedge clk); #1;
    chk(issueValid == 1'b0 && issueMask == 8'h00, "R1", "idle after reset",
        256'(issueMask), 256'(0));
    chk(fetchReady == 1'b1, "R1", "fetchReady after reset", 256'(fetchReady), 256'(1));
    @(negedge clk);

    // R10: empty and nothing offered
    for (int n = 0; n < 4; n++) begin
      step(0, randGroup(), 0, 3'd0);
      chk(seenValid == 1'b0, "R10", "no issue while empty", 256'(seenValid), 256'(0));
    end

    // R4: all flags clear -> eight single-word bundles in order
    g = randGroup();
    for (int k = 0; k < 8; k++) g[k*32] = 1'b0;
    step(1, g, 0, 3'd0);
    for (int k = 0; k < 8; k++) begin
      step(0, '0, 0, 3'd0);
      chk(seenMask == 8'(1 << k), "R4", "single-word bundle order",
          256'(seenMask), 256'(1 << k));
    end

    // R3: all flags set, including word 7 -> one full bundle
    g = randGroup();
    for (int k = 0; k < 8; k++) g[k*32] = 1'b1;
    step(1, g, 0, 3'd0);
    step(0, '0, 0, 3'd0);
    chk(seenMask == 8'hFF, "R3", "bundle stops at word 7", 256'(seenMask), 256'(8'hFF));
    step(0, '0, 0, 3'd0);

    // R8 / R9: redirect to word 5, then two groups
    g = randGroup();
    step(1, g, 0, 3'd0);
    step(0, '0, 1, 3'd5);
    chk(seenValid == 1'b0, "R8", "no issue in redirect cycle", 256'(seenValid), 256'(0));
    g = randGroup();
    for (int k = 0; k < 8; k++) g[k*32] = 1'b1;
    step(1, g, 0, 3'd0);
    step(0, '0, 0, 3'd0);
    chk(seenMask == 8'hE0, "R8", "dispatch starts at target word",
        256'(seenMask), 256'(8'hE0));
    step(1, g, 0, 3'd0);
    step(0, '0, 0, 3'd0);
    chk(seenMask == 8'hFF, "R9", "offset not reused", 256'(seenMask), 256'(8'hFF));

    // random traffic
    for (int n = 0; n < 3000; n++)
      step(($urandom % 4) != 0, randGroup(), ($urandom % 16) == 0, 3'($urandom));

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule